// File: doc/BRIEF.md
# Power-up strap capture and clock frequency source selector

This block sits in front of a programmable clock synthesizer whose configuration pins serve two purposes. Right after power-on the pins are read as inputs, which sets the frequency straps, an output-rate strap and a mode strap. The block samples them once, a fixed number of reference-clock cycles after power-on reset is released. Only after that sample does it let the pads turn around and drive clocks.

From the latched straps and the software register fields, the block forms the 6-bit frequency-table index used by the synthesizer. The index either comes from the five hardware straps, which reach the lower 32 table entries, or from a 6-bit software code, which reaches all 64. Every change of the index is announced by a one-cycle update strobe.

The block also gates the per-output enables with a global tri-state control. The latched mode strap decides the role of a shared pin. In one role it is an active-low power-down input. In the other it is an open-drain reset output that pulls low for a fixed time of about 4 ms after a watchdog timeout.

Top module: `strap_freq_sel`

## Requirements
- R1: While por_n is low, and after its release until the capture, freq_idx is 6'd10 (the pull defaults of the frequency straps: bits 1 and 3 set, bits 0, 2 and 4 clear). In the same interval use_24m is 1, strap_pad_oe is 0, every bit of out_oe is 0, and rst_pull_low and pwr_down are 0.
- R2: straps_done and strap_pad_oe rise exactly CAPTURE_DLY reference cycles after por_n is released. The strap pins are sampled on that same edge.
- R3: After the capture, changes on fs_strap, rate_strap and mode_strap have no effect on freq_idx, use_24m, pwr_down or rst_pull_low.
- R4: When sw_sel is 0, freq_idx is {1'b0, fs_strap[4:0]} as latched. fs_strap[0] is the least significant bit. The index appears one cycle after the capture edge.
- R5: When sw_sel is 1, freq_idx equals sw_code one cycle after the inputs change, for any of the 64 codes.
- R6: idx_upd is high for exactly the one cycle in which freq_idx takes a new value. It stays low when a change of source leaves the index value the same.
- R7: out_oe is all zeros when tri_all is 1 or before the capture. Otherwise it equals clk_en bit for bit (1 = running).
- R8: use_24m holds the latched rate strap: 1 selects the 24 MHz rate, 0 selects the 48 MHz rate.
- R9: With a latched mode strap of 1, pwr_down equals the inverse of pd_pin after the capture, and wdt_expire never asserts rst_pull_low.
- R10: With a latched mode strap of 0, a wdt_expire pulse makes rst_pull_low high from the next cycle on, for exactly PULSE_CYCLES cycles (57272 by default, 4 ms of a 14.318 MHz reference). pwr_down stays 0 in this mode.
- R11: A wdt_expire that arrives while the reset pulse is active neither restarts nor extends the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| fs_strap | input | 5 | Frequency strap levels read from the pads |
| rate_strap | input | 1 | Output-rate strap level (1 = 24 MHz) |
| mode_strap | input | 1 | Shared-pin role strap (1 = power-down input) |
| pd_pin | input | 1 | Level read on the shared pin |
| wdt_expire | input | 1 | Watchdog timeout event |
| sw_sel | input | 1 | Index source: 0 hardware straps, 1 software code |
| sw_code | input | 6 | Software frequency code |
| tri_all | input | 1 | Global tri-state of all clock outputs |
| clk_en | input | N_OUT | Per-output run enables |
| freq_idx | output | 6 | Selected frequency-table index |
| idx_upd | output | 1 | One-cycle strobe on every index change |
| straps_done | output | 1 | Straps captured |
| strap_pad_oe | output | 1 | Strap pads may drive clock outputs |
| out_oe | output | N_OUT | Per-output drive enables (0 = high impedance) |
| use_24m | output | 1 | Latched output-rate choice |
| pwr_down | output | 1 | Power-down request |
| rst_pull_low | output | 1 | Open-drain pull-low of the reset output |

## Verification
Suppose the capture state is wrong, for example a strap is resampled or taken on the wrong edge. The straps then show up through freq_idx and use_24m one cycle after they are disturbed. The capture edge count is measured directly from the por_n release. A wrong index register or strobe shows up in the first cycle after a source change as an unexpected or missing idx_upd, which the scoreboard catches because it holds exactly one entry per expected change. A corrupted pulse counter shows up only when the pulse ends, so every pulse is timed in full, including one that is retriggered partway through.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int IDX_W = 6;
  localparam int FS_W  = 5;
  localparam logic [FS_W-1:0] FS_PULL = 5'b01010;

  typedef logic [IDX_W-1:0] idx_t;

  function automatic idx_t hw_index(input logic [FS_W-1:0] fs);
    return {{(IDX_W-FS_W){1'b0}}, fs};
  endfunction

  function automatic idx_t pick_index(input logic sel, input idx_t sw,
                                      input logic [FS_W-1:0] fs);
    return sel ? sw : hw_index(fs);
  endfunction
endpackage

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int CAPTURE_DLY = 16
) (
  input  logic                      clk_ref,
  input  logic                      por_n,
  input  logic [strap_pkg::FS_W-1:0] fs_pad,
  input  logic                      rate_pad,
  input  logic                      mode_pad,
  output logic [strap_pkg::FS_W-1:0] fs_q,
  output logic                      rate_q,
  output logic                      mode_q,
  output logic                      done
);
  localparam int CW = $clog2(CAPTURE_DLY + 1);

  logic [CW-1:0] cnt;
  logic          cap_now;

  assign cap_now = !done && (cnt == CW'(CAPTURE_DLY - 1));

  always_ff @(posedge clk_ref or negedge por_n) begin
    if (!por_n) begin
      cnt    <= '0;
      done   <= 1'b0;
      fs_q   <= strap_pkg::FS_PULL;
      rate_q <= 1'b1;
      mode_q <= 1'b1;
    end else if (cap_now) begin
      done   <= 1'b1;
      fs_q   <= fs_pad;
      rate_q <= rate_pad;
      mode_q <= mode_pad;
    end else if (!done) begin
      cnt <= cnt + 1'b1;
    end
  end

  p_capture_edge_r2: assert property (@(posedge clk_ref) disable iff (!por_n)
    $rose(done) |-> $past(cnt) == CW'(CAPTURE_DLY - 1));
  p_latched_hold_r3: assert property (@(posedge clk_ref) disable iff (!por_n)
    (done && $past(done)) |-> ($stable(fs_q) && $stable(rate_q) && $stable(mode_q)));
  p_done_sticky_r2: assert property (@(posedge clk_ref) disable iff (!por_n)
    $past(done) |-> done);
endmodule

// File: rtl/freq_src_sel.sv
module freq_src_sel (
  input  logic                       clk_ref,
  input  logic                       por_n,
  input  logic                       sw_sel,
  input  strap_pkg::idx_t            sw_code,
  input  logic [strap_pkg::FS_W-1:0] fs_q,
  output strap_pkg::idx_t            freq_idx,
  output logic                       idx_upd
);
  strap_pkg::idx_t idx_next;
  logic            idx_change;

  assign idx_next   = strap_pkg::pick_index(sw_sel, sw_code, fs_q);
  assign idx_change = (idx_next != freq_idx);

  always_ff @(posedge clk_ref or negedge por_n) begin
    if (!por_n) begin
      freq_idx <= strap_pkg::hw_index(strap_pkg::FS_PULL);
      idx_upd  <= 1'b0;
    end else begin
      freq_idx <= idx_next;
      idx_upd  <= idx_change;
    end
  end

  p_strobe_marks_change_r6: assert property (@(posedge clk_ref) disable iff (!por_n)
    idx_upd |-> freq_idx != $past(freq_idx));
  p_quiet_when_no_strobe_r6: assert property (@(posedge clk_ref) disable iff (!por_n)
    !idx_upd |-> $stable(freq_idx));
  p_sw_follow_r5: assert property (@(posedge clk_ref) disable iff (!por_n)
    $past(sw_sel) |-> freq_idx == $past(sw_code));
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
  parameter int PULSE_CYCLES = 57272
) (
  input  logic clk_ref,
  input  logic por_n,
  input  logic arm,
  input  logic expire,
  output logic pull_low
);
  localparam int PW = $clog2(PULSE_CYCLES + 1);

  logic [PW-1:0] cnt;
  logic          busy;
  logic          start;

  assign busy     = (cnt != '0);
  assign start    = arm && expire && !busy;
  assign pull_low = busy;

  always_ff @(posedge clk_ref or negedge por_n) begin
    if (!por_n)     cnt <= '0;
    else if (start) cnt <= PW'(PULSE_CYCLES);
    else if (busy)  cnt <= cnt - 1'b1;
  end

  // pulse-length checker, counts busy cycles
  logic [PW:0] seen;
  always_ff @(posedge clk_ref or negedge por_n) begin
    if (!por_n)    seen <= '0;
    else if (busy) seen <= seen + 1'b1;
    else           seen <= '0;
  end

  p_pulse_len_r10: assert property (@(posedge clk_ref) disable iff (!por_n)
    $fell(busy) |-> seen == (PW+1)'(PULSE_CYCLES));
  p_no_extend_r11: assert property (@(posedge clk_ref) disable iff (!por_n)
    (busy && $past(busy)) |-> cnt < $past(cnt));
  p_idle_unarmed_r9: assert property (@(posedge clk_ref) disable iff (!por_n)
    !arm |-> !busy);
endmodule

// File: rtl/strap_freq_sel.sv
module strap_freq_sel #(
  parameter int CAPTURE_DLY  = 16,
  parameter int PULSE_CYCLES = 57272,
  parameter int N_OUT        = 26
) (
  input  logic             clk_ref,
  input  logic             por_n,
  input  logic [4:0]       fs_strap,
  input  logic             rate_strap,
  input  logic             mode_strap,
  input  logic             pd_pin,
  input  logic             wdt_expire,
  input  logic             sw_sel,
  input  logic [5:0]       sw_code,
  input  logic             tri_all,
  input  logic [N_OUT-1:0] clk_en,
  output logic [5:0]       freq_idx,
  output logic             idx_upd,
  output logic             straps_done,
  output logic             strap_pad_oe,
  output logic [N_OUT-1:0] out_oe,
  output logic             use_24m,
  output logic             pwr_down,
  output logic             rst_pull_low
);
  logic [4:0] fs_q;
  logic       mode_q;
  logic       pd_role;
  logic       wdt_arm;

  strap_capture #(.CAPTURE_DLY(CAPTURE_DLY)) u_cap (
    .clk_ref (clk_ref), .por_n (por_n),
    .fs_pad  (fs_strap), .rate_pad (rate_strap), .mode_pad (mode_strap),
    .fs_q    (fs_q), .rate_q (use_24m), .mode_q (mode_q), .done (straps_done)
  );

  freq_src_sel u_sel (
    .clk_ref (clk_ref), .por_n (por_n), .sw_sel (sw_sel), .sw_code (sw_code),
    .fs_q    (fs_q), .freq_idx (freq_idx), .idx_upd (idx_upd)
  );

  assign pd_role = straps_done && mode_q;
  assign wdt_arm = straps_done && !mode_q;

  rst_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_rst (
    .clk_ref (clk_ref), .por_n (por_n), .arm (wdt_arm),
    .expire  (wdt_expire), .pull_low (rst_pull_low)
  );

  assign strap_pad_oe = straps_done;
  assign pwr_down     = pd_role && !pd_pin;

  for (genvar g = 0; g < N_OUT; g++) begin : g_oe
    assign out_oe[g] = straps_done && !tri_all && clk_en[g];
  end

  p_hiz_r7: assert property (@(posedge clk_ref) disable iff (!por_n)
    (tri_all || !straps_done) |-> out_oe == '0);
  p_pads_input_r1: assert property (@(posedge clk_ref) disable iff (!por_n)
    !strap_pad_oe |-> (out_oe == '0 && !rst_pull_low && !pwr_down));
  p_roles_exclusive_r9: assert property (@(posedge clk_ref) disable iff (!por_n)
    !(pwr_down && rst_pull_low));
endmodule

// File: tb/test_strap_freq_sel.sv
module test_strap_freq_sel;
  localparam int DLY = 16;
  localparam int PULSE = 57272;
  localparam int NO = 26;

  logic clk_ref = 1'b0;
  logic por_n = 1'b0;
  logic [4:0] fs_strap = 5'b01010;
  logic rate_strap = 1'b1, mode_strap = 1'b1, pd_pin = 1'b1, wdt_expire = 1'b0;
  logic sw_sel = 1'b0, tri_all = 1'b0;
  logic [5:0] sw_code = '0;
  logic [NO-1:0] clk_en = '0;
  logic [5:0] freq_idx;
  logic idx_upd, straps_done, strap_pad_oe, use_24m, pwr_down, rst_pull_low;
  logic [NO-1:0] out_oe;

  always #2.5 clk_ref = ~clk_ref;

  strap_freq_sel i_strap_freq_sel (.*);

  int n_cmp = 0, n_bad = 0;
  logic [5:0] exp_q[$];
  logic [5:0] model_idx = 6'd10;
  logic [4:0] model_fs = 5'b01010;
  bit finished = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // driver: expected index computed from the rules, pushed only on a change
  task automatic expect_index(input logic s, input logic [5:0] code);
    logic [5:0] e;
    e = s ? code : {1'b0, model_fs};
    if (e != model_idx) exp_q.push_back(e);
    model_idx = e;
  endtask

  task automatic set_src(input logic s, input logic [5:0] code);
    @(negedge clk_ref);
    sw_sel = s; sw_code = code;
    expect_index(s, code);
    repeat (3) @(negedge clk_ref);
  endtask

  // monitor: every strobe pops and compares
  always @(negedge clk_ref) begin
    if (por_n && idx_upd) begin
      if (exp_q.size() == 0) chk("R6 unexpected strobe", freq_idx, model_idx + 64);
      else chk("R4/R5/R6 index at strobe", freq_idx, exp_q.pop_front());
    end
  end

  task automatic power_up(input logic [4:0] fs, input logic r, input logic m);
    int n;
    por_n = 1'b0; fs_strap = fs; rate_strap = r; mode_strap = m;
    sw_sel = 1'b0; exp_q.delete();
    model_idx = 6'd10; model_fs = 5'b01010;
    repeat (3) @(negedge clk_ref);
    chk("R1 reset idx", freq_idx, 10);
    chk("R1 reset rate", use_24m, 1);
    chk("R1 reset oe", out_oe, 0);
    chk("R1 reset pad oe", strap_pad_oe, 0);
    chk("R1 reset pulse", rst_pull_low, 0);
    por_n = 1'b1;
    model_fs = fs;
    expect_index(1'b0, 6'd0);
    n = 0;
    while (!straps_done && n < 1000) begin
      @(negedge clk_ref); n++;
      if (n == DLY - 1) chk("R1 idx before capture", freq_idx, 10);
    end
    chk("R2 capture cycle", n, DLY);
    chk("R2 pad oe", strap_pad_oe, 1);
    repeat (2) @(negedge clk_ref);
    chk("R4 hw index", freq_idx, {1'b0, fs});
    chk("R8 rate latched", use_24m, r);
  endtask

  initial begin
    int len;
    // phase 1: power-down role, 48 MHz rate
    clk_en = 26'h2A5_5A3C;
    power_up(5'b10011, 1'b0, 1'b1);
    fs_strap = 5'b00100; rate_strap = 1'b1; mode_strap = 1'b0;
    repeat (4) @(negedge clk_ref);
    chk("R3 idx after strap change", freq_idx, 19);
    chk("R3 rate after strap change", use_24m, 0);
    chk("R7 oe follows enables", out_oe, 26'h2A5_5A3C);
    tri_all = 1'b1; @(negedge clk_ref);
    chk("R7 tri-state", out_oe, 0);
    tri_all = 1'b0; clk_en = 26'h155_0F0F; @(negedge clk_ref);
    chk("R7 new enables", out_oe, 26'h155_0F0F);
    set_src(1'b1, 6'd63);
    set_src(1'b1, 6'd0);
    set_src(1'b1, 6'd41);
    set_src(1'b1, 6'd19);
    set_src(1'b0, 6'd19);   // R6: same value, no strobe
    chk("R6 value kept", freq_idx, 19);
    set_src(1'b1, 6'd32);
    chk("R5 upper half", freq_idx, 32);
    set_src(1'b0, 6'd32);
    pd_pin = 1'b0; @(negedge clk_ref);
    chk("R9 power-down asserted", pwr_down, 1);
    pd_pin = 1'b1; @(negedge clk_ref);
    chk("R9 power-down released", pwr_down, 0);
    wdt_expire = 1'b1; @(negedge clk_ref); wdt_expire = 1'b0;
    repeat (3) @(negedge clk_ref);
    chk("R9 watchdog ignored", rst_pull_low, 0);
    chk("R9/R6 queue drained", exp_q.size(), 0);

    // phase 2: reset-output role, pull defaults
    power_up(5'b01010, 1'b1, 1'b0);
    pd_pin = 1'b0; @(negedge clk_ref);
    chk("R10 no power-down in reset role", pwr_down, 0);
    mode_strap = 1'b1; @(negedge clk_ref);
    chk("R3 mode change ignored", pwr_down, 0);
    chk("R10 idle before expire", rst_pull_low, 0);
    wdt_expire = 1'b1; @(negedge clk_ref); wdt_expire = 1'b0;
    len = 0;
    while (rst_pull_low && len < PULSE + 100) begin
      len++;
      if (len == 1000) wdt_expire = 1'b1;
      if (len == 1001) wdt_expire = 1'b0;
      @(negedge clk_ref);
    end
    chk("R10/R11 pulse length", len, PULSE);
    repeat (5) @(negedge clk_ref);
    chk("R11 no restart", rst_pull_low, 0);
    chk("R6 queue drained", exp_q.size(), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_ref);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule